// File: doc/BRIEF.md
# D-PHY Test-Port Configuration Sequencer

This block brings up the analog PHY of a MIPI display link through the PHY's byte-wide test port. A single start pulse, together with a per-lane bit rate in Mbps and the PLL input (N) and feedback (M) divider values, launches a fixed list of 25 register writes. These writes set the PLL, the bias and termination circuits and the lane timing counts. Before any write is issued, the rate selects one row of a 39-row rate-range table. That row supplies the PLL charge-pump, loop-filter and frequency-range settings. The lane timing counts come from nanosecond targets, converted into byte-clock or unit-interval counts at the requested rate.

Every write uses a two-phase handshake on the test clock. The falling edge latches an 8-bit register code, and the next rising edge commits the data byte. Each protocol step is held for `HOLD_CYC` system clocks so that the PHY's setup and hold limits are met. The block reports busy while a sequence runs. It pulses done once the last commit has been held, and it raises an error flag when the requested rate lies beyond the table.

Top module: `dphy_cfg_seq`

## Requirements
- R1: After reset, busy, done, err, tst_clk, tst_en and tst_din are all 0.
- R2: Each write runs five steps, each held for HOLD_CYC clocks, in this order:
  1. tst_clk rises while tst_en stays 0.
  2. tst_en goes to 1 and tst_din carries the code.
  3. tst_clk falls, which latches the code.
  4. tst_en goes to 0 and tst_din carries the data.
  5. tst_clk rises, which commits the data.

  tst_din is stable at the falling edge, and tst_clk stays low for exactly 2*HOLD_CYC clocks.
- R3: One accepted start produces exactly 25 commits. Their codes, in order, are:
  - 0x10, 0x11, 0x12, 0x44
  - 0x17, 0x18, 0x19, 0x18, 0x19
  - 0x22, 0x22, 0x20, 0x21, 0x21
  - 0x60 to 0x65
  - 0x70 to 0x74
- R4: The code-0x10 byte is 0x83 OR (v<<3), where v is the 3-bit VCO band.
  - v is 0 for rates below 200 Mbps.
  - Otherwise v is ((rate+100)/200) mod 8.
- R5: The table row chosen is the first, in ascending limit order, whose upper limit is at least the rate. From that row:
  - Code 0x11 takes the 4-bit charge-pump value.
  - Code 0x12 takes 0xC0 OR the 6-bit filter value.
  - Code 0x44 takes the 6-bit range value shifted left by 1.
- R6: The divider bytes are written as follows:
  - Code 0x17 is (N-1) mod 128.
  - The first 0x18 is (M-1) bits 4:0.
  - The second 0x18 is 0x80 OR (M-1) bits 8:5.
  - Both 0x19 writes carry 0x30.
- R7: The fixed bias and termination bytes are:
  - 0x07 then 0x87 for code 0x22.
  - 0x4D for code 0x20.
  - 0x3D then 0xDF for code 0x21.
- R8: Let B(t) = ceil(floor(t*rate/8)/1000) and U(t) = ceil(t*rate/1000). The clock-lane bytes are, for codes 0x60 to 0x65 in order:
  - 0x80|B(500)
  - 0x80|U(40)
  - 0x40|B(300)
  - 0x80|U(100)
  - 0x20|B(100)
  - 0x20|(B(60)+7)

  Every value is taken mod 256.
- R9: The data-lane bytes are, for codes 0x70 to 0x74 in order:
  - 0x80|B(500)
  - 0x80|(U(50)+20)
  - 0x40|(B(140)+2)
  - 0x80|(U(60)+8)
  - 0x20|B(100)

  Every value is taken mod 256.
- R10: A start with a rate above 1500 sets err on the next clock and issues no write: busy stays 0 and tst_clk does not move. The next accepted start clears err.
- R11: A start that arrives while busy is ignored, and the running sequence completes with its original parameters.
- R12: done is high for exactly one clock, in the clock after the last commit's hold ends. busy falls at that same edge, and a start presented while done is high is accepted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled when idle |
| lane_rate | input | RATE_W | Per-lane bit rate in Mbps |
| in_div | input | IDIV_W | PLL input divider N |
| fb_div | input | FDIV_W | PLL feedback divider M |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Last start carried an out-of-table rate |
| tst_clk | output | 1 | Test-port clock |
| tst_en | output | 1 | Test-port enable, high while a code is presented |
| tst_din | output | 8 | Test-port code/data byte |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. The bench raises start exactly in the cycle where done is high, with different rate and divider values. It then judges the second run by its full 25-write list and by busy being high on the next cycle. A start held during the final commit hold of a run must instead be dropped. The bench judges this by the first run's writes staying intact and by no further activity once that run ends.

// File: rtl/dphy_cfg_pkg.sv
package dphy_cfg_pkg;

  localparam int NUM_WR   = 25;
  localparam int NUM_ROWS = 39;
  localparam int MAX_RATE = 1500;
  localparam int WIDX_W   = $clog2(NUM_WR);

  typedef enum logic [2:0] {
    ST_CLK_UP, ST_CODE, ST_LATCH, ST_DATA, ST_COMMIT
  } step_e;

  typedef struct packed {
    logic [5:0] hs;
    logic [3:0] icp;
    logic [5:0] lpf;
    logic [2:0] vco;
  } analog_t;

  // Row layout: {upper limit[10:0], range[5:0], charge pump[3:0], filter[5:0]}
  function automatic logic [26:0] rate_row(int i);
    case (i)
      0:  return {11'd89,   6'h00, 4'h1, 6'h02};
      1:  return {11'd99,   6'h10, 4'h1, 6'h02};
      2:  return {11'd109,  6'h20, 4'h1, 6'h02};
      3:  return {11'd129,  6'h01, 4'h1, 6'h01};
      4:  return {11'd139,  6'h11, 4'h1, 6'h01};
      5:  return {11'd149,  6'h21, 4'h1, 6'h01};
      6:  return {11'd169,  6'h02, 4'h9, 6'h02};
      7:  return {11'd179,  6'h12, 4'h9, 6'h02};
      8:  return {11'd199,  6'h22, 4'h9, 6'h02};
      9:  return {11'd219,  6'h03, 4'h2, 6'h02};
      10: return {11'd239,  6'h13, 4'h2, 6'h02};
      11: return {11'd249,  6'h23, 4'h2, 6'h02};
      12: return {11'd269,  6'h04, 4'h9, 6'h04};
      13: return {11'd299,  6'h14, 4'h9, 6'h04};
      14: return {11'd329,  6'h05, 4'h1, 6'h01};
      15: return {11'd359,  6'h15, 4'h1, 6'h01};
      16: return {11'd399,  6'h25, 4'h1, 6'h01};
      17: return {11'd449,  6'h06, 4'h6, 6'h04};
      18: return {11'd499,  6'h16, 4'h6, 6'h04};
      19: return {11'd549,  6'h07, 4'h6, 6'h08};
      20: return {11'd599,  6'h17, 4'h6, 6'h08};
      21: return {11'd649,  6'h08, 4'h6, 6'h04};
      22: return {11'd699,  6'h18, 4'h6, 6'h04};
      23: return {11'd749,  6'h09, 4'h6, 6'h04};
      24: return {11'd799,  6'h19, 4'h6, 6'h04};
      25: return {11'd849,  6'h29, 4'h6, 6'h04};
      26: return {11'd899,  6'h39, 4'h6, 6'h04};
      27: return {11'd949,  6'h0a, 4'hb, 6'h10};
      28: return {11'd999,  6'h1a, 4'hb, 6'h10};
      29: return {11'd1049, 6'h2a, 4'hb, 6'h10};
      30: return {11'd1099, 6'h3a, 4'hb, 6'h10};
      31: return {11'd1149, 6'h0b, 4'hb, 6'h08};
      32: return {11'd1199, 6'h1b, 4'hb, 6'h08};
      33: return {11'd1249, 6'h2b, 4'hb, 6'h08};
      34: return {11'd1299, 6'h3b, 4'hb, 6'h08};
      35: return {11'd1349, 6'h0c, 4'hb, 6'h08};
      36: return {11'd1399, 6'h1c, 4'hb, 6'h08};
      37: return {11'd1449, 6'h2c, 4'hb, 6'h08};
      default: return {11'd1500, 6'h3c, 4'hb, 6'h08};
    endcase
  endfunction

  function automatic logic [2:0] vco_band(int rate);
    if (rate < 200) return 3'd0;
    return 3'((rate + 100) / 200);
  endfunction

  // Byte-clock count: truncate the /8 first, then round the /1000 up
  function automatic int byte_clks(int ns, int rate);
    int eighth;
    eighth = (ns * rate) / 8;
    return (eighth + 999) / 1000;
  endfunction

  function automatic int ui_cnt(int ns, int rate);
    return (ns * rate + 999) / 1000;
  endfunction

  function automatic logic [7:0] code_of(int w);
    case (w)
      0: return 8'h10;  1: return 8'h11;  2: return 8'h12;  3: return 8'h44;
      4: return 8'h17;  5: return 8'h18;  6: return 8'h19;  7: return 8'h18;
      8: return 8'h19;  9: return 8'h22;  10: return 8'h22; 11: return 8'h20;
      12: return 8'h21; 13: return 8'h21;
      default: begin
        if (w < 20) return 8'(8'h60 + w - 14);
        return 8'(8'h70 + w - 20);
      end
    endcase
  endfunction

endpackage

// File: rtl/dphy_rate_lookup.sv
module dphy_rate_lookup
  import dphy_cfg_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate,
  output logic              hit,
  output analog_t           ana
);

  logic [26:0] row;

  always_comb begin
    hit = 1'b0;
    ana = '0;
    row = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      row = rate_row(i);
      if (!hit && (int'(rate) <= int'(row[26:16]))) begin
        hit     = 1'b1;
        ana.hs  = row[15:10];
        ana.icp = row[9:6];
        ana.lpf = row[5:0];
      end
    end
    ana.vco = vco_band(int'(rate));
  end

endmodule

// File: rtl/dphy_write_list.sv
module dphy_write_list
  import dphy_cfg_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int IDIV_W = 8,
  parameter int FDIV_W = 10
) (
  input  logic [WIDX_W-1:0] widx,
  input  logic [RATE_W-1:0] rate,
  input  logic [IDIV_W-1:0] ndiv,
  input  logic [FDIV_W-1:0] mdiv,
  input  analog_t           ana,
  output logic [7:0]        code,
  output logic [7:0]        data
);

  int r, nm1, mm1;

  always_comb begin
    r    = int'(rate);
    nm1  = int'(ndiv) - 1;
    mm1  = int'(mdiv) - 1;
    code = code_of(int'(widx));
    case (int'(widx))
      0:  data = 8'h83 | {2'b00, ana.vco, 3'b000};
      1:  data = {4'h0, ana.icp};
      2:  data = 8'hC0 | {2'b00, ana.lpf};
      3:  data = {1'b0, ana.hs, 1'b0};
      4:  data = 8'(nm1 & 127);
      5:  data = 8'(mm1 & 31);
      6:  data = 8'h30;
      7:  data = 8'(8'h80 | ((mm1 >> 5) & 15));
      8:  data = 8'h30;
      9:  data = 8'h07;
      10: data = 8'h87;
      11: data = 8'h4D;
      12: data = 8'h3D;
      13: data = 8'hDF;
      14: data = 8'(8'h80 | byte_clks(500, r));
      15: data = 8'(8'h80 | ui_cnt(40, r));
      16: data = 8'(8'h40 | byte_clks(300, r));
      17: data = 8'(8'h80 | ui_cnt(100, r));
      18: data = 8'(8'h20 | byte_clks(100, r));
      19: data = 8'(8'h20 | (byte_clks(60, r) + 7));
      20: data = 8'(8'h80 | byte_clks(500, r));
      21: data = 8'(8'h80 | (ui_cnt(50, r) + 20));
      22: data = 8'(8'h40 | (byte_clks(140, r) + 2));
      23: data = 8'(8'h80 | (ui_cnt(60, r) + 8));
      default: data = 8'(8'h20 | byte_clks(100, r));
    endcase
  end

endmodule

// File: rtl/dphy_port_engine.sv
module dphy_port_engine
  import dphy_cfg_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [7:0]        code,
  input  logic [7:0]        data,
  output logic              busy,
  output logic              done,
  output logic [WIDX_W-1:0] widx,
  output logic              tst_clk,
  output logic              tst_en,
  output logic [7:0]        tst_din,
  output logic              commit_ev
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0]     HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [WIDX_W-1:0] LAST_W    = WIDX_W'(NUM_WR - 1);

  step_e         step;
  logic [CW-1:0] hcnt;
  logic          step_end;

  assign step_end  = busy && (hcnt == HOLD_LAST);
  assign commit_ev = step_end && (step == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      widx    <= '0;
      step    <= ST_CLK_UP;
      hcnt    <= '0;
      tst_clk <= 1'b0;
      tst_en  <= 1'b0;
      tst_din <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy    <= 1'b1;
          widx    <= '0;
          step    <= ST_CLK_UP;
          hcnt    <= '0;
          tst_clk <= 1'b1;
          tst_en  <= 1'b0;
        end
      end else if (step_end) begin
        hcnt <= '0;
        case (step)
          ST_CLK_UP: begin
            step    <= ST_CODE;
            tst_en  <= 1'b1;
            tst_din <= code;
          end
          ST_CODE: begin
            step    <= ST_LATCH;
            tst_clk <= 1'b0;
          end
          ST_LATCH: begin
            step    <= ST_DATA;
            tst_en  <= 1'b0;
            tst_din <= data;
          end
          ST_DATA: begin
            step    <= ST_COMMIT;
            tst_clk <= 1'b1;
          end
          default: begin
            step <= ST_CLK_UP;
            if (widx == LAST_W) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              widx <= widx + 1'b1;
            end
          end
        endcase
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dphy_cfg_seq.sv
module dphy_cfg_seq
  import dphy_cfg_pkg::*;
#(
  parameter int HOLD_CYC = 2,
  parameter int RATE_W   = 11,
  parameter int IDIV_W   = 8,
  parameter int FDIV_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] lane_rate,
  input  logic [IDIV_W-1:0] in_div,
  input  logic [FDIV_W-1:0] fb_div,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              tst_clk,
  output logic              tst_en,
  output logic [7:0]        tst_din
);

  logic              hit;
  analog_t           ana_in, ana_q;
  logic [RATE_W-1:0] rate_q;
  logic [IDIV_W-1:0] ndiv_q;
  logic [FDIV_W-1:0] mdiv_q;
  logic [WIDX_W-1:0] widx;
  logic [7:0]        wr_code, wr_data;
  logic              go_ev, commit_ev;

  assign go_ev = start && !busy && hit;

  dphy_rate_lookup #(.RATE_W(RATE_W)) u_lookup (
    .rate (lane_rate),
    .hit  (hit),
    .ana  (ana_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= 1'b0;
      rate_q <= '0;
      ndiv_q <= '0;
      mdiv_q <= '0;
      ana_q  <= '0;
    end else if (start && !busy) begin
      err <= !hit;
      if (hit) begin
        rate_q <= lane_rate;
        ndiv_q <= in_div;
        mdiv_q <= fb_div;
        ana_q  <= ana_in;
      end
    end
  end

  dphy_write_list #(.RATE_W(RATE_W), .IDIV_W(IDIV_W), .FDIV_W(FDIV_W)) u_list (
    .widx (widx),
    .rate (rate_q),
    .ndiv (ndiv_q),
    .mdiv (mdiv_q),
    .ana  (ana_q),
    .code (wr_code),
    .data (wr_data)
  );

  dphy_port_engine #(.HOLD_CYC(HOLD_CYC)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_ev),
    .code      (wr_code),
    .data      (wr_data),
    .busy      (busy),
    .done      (done),
    .widx      (widx),
    .tst_clk   (tst_clk),
    .tst_en    (tst_en),
    .tst_din   (tst_din),
    .commit_ev (commit_ev)
  );

endmodule

// File: rtl/dphy_cfg_seq_chk.sv
module dphy_cfg_seq_chk
  import dphy_cfg_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RATE_W-1:0] lane_rate,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              tst_clk,
  input logic              tst_en,
  input logic [7:0]        tst_din,
  input logic              go_ev,
  input logic              commit_ev
);

  logic [5:0] n_commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_commit <= '0;
    else if (go_ev) n_commit <= '0;
    else if (commit_ev) n_commit <= n_commit + 1'b1;
  end

  AST_EN_AT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_clk) |-> tst_en); // R2
  AST_EN_LOW_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_clk) |-> !tst_en); // R2
  AST_CODE_STABLE_AT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_clk) |-> $stable(tst_din)); // R2
  AST_WRITE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (n_commit == 6'(NUM_WR))); // R3
  AST_BAD_RATE_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (int'(lane_rate) > MAX_RATE)) |=> (err && !busy)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R12

endmodule

bind dphy_cfg_seq dphy_cfg_seq_chk #(.RATE_W(RATE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .lane_rate (lane_rate),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .tst_clk   (tst_clk),
  .tst_en    (tst_en),
  .tst_din   (tst_din),
  .go_ev     (go_ev),
  .commit_ev (commit_ev)
);

// File: tb/tb_dphy_cfg_seq.sv
module tb_dphy_cfg_seq;

  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [10:0] lane_rate = '0;
  logic [7:0]  in_div = '0;
  logic [9:0]  fb_div = '0;
  logic        busy, done, err, tst_clk, tst_en;
  logic [7:0]  tst_din;

  always #4 clk = ~clk;

  dphy_cfg_seq #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_rate(lane_rate),
    .in_div(in_div), .fb_div(fb_div), .busy(busy), .done(done), .err(err),
    .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench-side reference tables
  int lim_t[39] = '{89,99,109,129,139,149,169,179,199,219,239,249,269,299,329,359,399,
                    449,499,549,599,649,699,749,799,849,899,949,999,1049,1099,1149,
                    1199,1249,1299,1349,1399,1449,1500};
  int rng_t[39] = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,'h23,'h04,
                    'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,'h18,'h09,'h19,'h29,
                    'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,'h2b,'h3b,'h0c,'h1c,'h2c,'h3c};
  int cp_t[39]  = '{1,1,1,1,1,1,9,9,9,2,2,2,9,9,1,1,1,6,6,6,6,6,6,6,6,6,6,
                    11,11,11,11,11,11,11,11,11,11,11,11};
  int lf_t[39]  = '{2,2,2,1,1,1,2,2,2,2,2,2,4,4,1,1,1,4,4,8,8,4,4,4,4,4,4,
                    16,16,16,16,8,8,8,8,8,8,8,8};
  int code_t[25] = '{'h10,'h11,'h12,'h44,'h17,'h18,'h19,'h18,'h19,'h22,'h22,'h20,
                     'h21,'h21,'h60,'h61,'h62,'h63,'h64,'h65,'h70,'h71,'h72,'h73,'h74};

  function automatic int bc(int t, int r);
    int q = (t * r) / 8;
    int c = q / 1000;
    if (q % 1000 != 0) c++;
    return c;
  endfunction

  function automatic int ui(int t, int r);
    int c = (t * r) / 1000;
    if ((t * r) % 1000 != 0) c++;
    return c;
  endfunction

  function automatic int exp_data(int w, int r, int n, int m);
    int row = 38;
    int v;
    for (int k = 38; k >= 0; k--) if (lim_t[k] >= r) row = k;
    v = (r < 200) ? 0 : ((r + 100) / 200) % 8;
    case (w)
      0: return 'h83 | (v * 8);
      1: return cp_t[row] % 16;
      2: return 'hC0 | lf_t[row];
      3: return rng_t[row] * 2;
      4: return (n - 1) % 128;
      5: return (m - 1) % 32;
      6, 8: return 'h30;
      7: return 'h80 | (((m - 1) / 32) % 16);
      9: return 'h07;
      10: return 'h87;
      11: return 'h4D;
      12: return 'h3D;
      13: return 'hDF;
      14, 20: return ('h80 | bc(500, r)) % 256;
      15: return ('h80 | ui(40, r)) % 256;
      16: return ('h40 | bc(300, r)) % 256;
      17: return ('h80 | ui(100, r)) % 256;
      18, 24: return ('h20 | bc(100, r)) % 256;
      19: return ('h20 | (bc(60, r) + 7)) % 256;
      21: return ('h80 | (ui(50, r) + 20)) % 256;
      22: return ('h40 | (bc(140, r) + 2)) % 256;
      default: return ('h80 | (ui(60, r) + 8)) % 256;
    endcase
  endfunction

  function automatic string tag_of(int w);
    if (w == 0) return "R4";
    if (w < 4) return "R5";
    if (w < 9) return "R6";
    if (w < 14) return "R7";
    if (w < 20) return "R8";
    return "R9";
  endfunction

  // Protocol monitor: latch code on falling edge, capture data on rising edge
  logic prev_clk = 1'b0;
  bit   armed = 0;
  int   low_cnt = 0;
  int   ncap = 0;
  logic [7:0] lat_code;
  int   cap_c[64];
  int   cap_d[64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_clk && !tst_clk) begin
        lat_code = tst_din;
        armed = 1;
        low_cnt = 0;
        check(tst_en == 1'b1, "R2", "tst_en at latch", int'(tst_en), 1);
      end else if (!prev_clk && tst_clk && armed) begin
        check(tst_en == 1'b0, "R2", "tst_en at commit", int'(tst_en), 0);
        check(low_cnt == 2 * HOLD, "R2", "clock low width", low_cnt, 2 * HOLD);
        if (ncap < 64) begin
          cap_c[ncap] = int'(lat_code);
          cap_d[ncap] = int'(tst_din);
        end
        ncap++;
        armed = 0;
      end
      low_cnt++;
    end
    prev_clk = tst_clk;
  end

  task automatic launch(int r, int n, int m);
    @(negedge clk);
    lane_rate = 11'(r); in_div = 8'(n); fb_div = 10'(m);
    ncap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check(done == 1'b1, "R12", "done seen", int'(done), 1);
    check(busy == 1'b0, "R12", "busy low with done", int'(busy), 0);
  endtask

  task automatic verify(int r, int n, int m);
    check(ncap == 25, "R3", "write count", ncap, 25);
    for (int w = 0; w < 25 && w < ncap; w++) begin
      check(cap_c[w] == code_t[w], "R3", $sformatf("code of write %0d", w), cap_c[w], code_t[w]);
      check(cap_d[w] == exp_data(w, r, n, m), tag_of(w),
            $sformatf("data of write %0d rate %0d", w, r), cap_d[w], exp_data(w, r, n, m));
    end
  endtask

  task automatic full_run(int r, int n, int m);
    launch(r, n, m);
    check(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
    wait_done();
    verify(r, n, m);
    @(negedge clk);
    check(done == 1'b0, "R12", "done one cycle", int'(done), 0);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(busy == 0, "R1", "busy", int'(busy), 0);
    check(done == 0, "R1", "done", int'(done), 0);
    check(err == 0, "R1", "err", int'(err), 0);
    check(tst_clk == 0, "R1", "tst_clk", int'(tst_clk), 0);
    check(tst_en == 0, "R1", "tst_en", int'(tst_en), 0);
    check(tst_din == 0, "R1", "tst_din", int'(tst_din), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed table boundaries and VCO corners
    full_run(80, 1, 6);
    full_run(89, 2, 512);
    full_run(90, 3, 100);
    full_run(199, 1, 8);
    full_run(200, 4, 14);
    full_run(1499, 1, 500);
    full_run(1500, 1, 512);

    // R10: out-of-table rate
    begin
      logic clk_before;
      clk_before = tst_clk;
      launch(1501, 1, 100);
      check(err == 1'b1, "R10", "err after bad rate", int'(err), 1);
      check(busy == 1'b0, "R10", "busy after bad rate", int'(busy), 0);
      repeat (10) @(negedge clk);
      check(ncap == 0, "R10", "writes after bad rate", ncap, 0);
      check(tst_clk == clk_before, "R10", "tst_clk still", int'(tst_clk), int'(clk_before));
      launch(2047, 1, 100);
      check(err == 1'b1, "R10", "err at max input", int'(err), 1);
      full_run(600, 2, 200);
      check(err == 1'b0, "R10", "err cleared", int'(err), 0);
    end

    // R11: start while busy ignored
    launch(700, 2, 300);
    repeat (30) @(negedge clk);
    lane_rate = 11'd300; in_div = 8'd5; fb_div = 10'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lane_rate = 11'd1000;
    wait_done();
    verify(700, 2, 300);
    repeat (6) @(negedge clk);
    check(busy == 1'b0, "R11", "no second run", int'(busy), 0);
    check(ncap == 25, "R11", "no extra writes", ncap, 25);

    // Start held through the final commit hold: dropped
    launch(450, 3, 90);
    while (!(busy && tst_clk && ncap == 25)) @(negedge clk);
    start = 1'b1; lane_rate = 11'd900;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    verify(450, 3, 90);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R11", "late start dropped", int'(busy), 0);

    // R12: start in the done cycle is accepted
    launch(333, 1, 60);
    wait_done();
    verify(333, 1, 60);
    lane_rate = 11'd1234; in_div = 8'd2; fb_div = 10'd180;
    ncap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R12", "start in done cycle accepted", int'(busy), 1);
    wait_done();
    verify(1234, 2, 180);

    // Random runs
    for (int k = 0; k < 15; k++) begin
      int r = int'($urandom_range(1500, 0));
      int n = int'($urandom_range(8, 1));
      int m = 2 * int'($urandom_range(256, 3));
      full_run(r, n, m);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule